// File: doc/BRIEF.md
# Four-Tap Streaming FIR Filter with Valid Tracking

The block filters a stream of 4-bit unsigned samples with a fixed four-tap kernel. A sample is offered on each clock together with a strobe. Accepted samples move through a three-stage delay line. The newest sample and the three held samples are each multiplied by a constant weight, and the weighted values are added. The total is registered onto a 10-bit output. The weights are 1, 3, 2 and 1, applied from the newest sample to the oldest.

Each delay stage carries a flag bit that moves with its sample. The output is marked valid only when all four taps hold real samples. As a result, nothing computed from cleared reset contents is ever presented as a result.

A cycle without the strobe freezes the delay line. Such a cycle produces no valid output, so a gappy stream gives the same results as a dense one.

Top module: `fir4_stream`

## Requirements
- R1: While reset is applied and on the first edge after its release, `out_valid` is 0 and `out_data` is 0.
- R2: One clock edge after a sample is accepted, and once the taps are full, `out_data` equals 1·x[n] + 3·x[n-1] + 2·x[n-2] + 1·x[n-3]. Here x[n] is the sample just accepted and the others are the three samples accepted before it.
- R3: After reset, the first three accepted samples give `out_valid` = 0. The fourth and every later accepted sample give `out_valid` = 1.
- R4: A cycle with `in_valid` = 0 leaves the delay line unchanged and makes `out_valid` 0 after the next edge.
- R5: `out_data` is 0 whenever `out_valid` is 0.
- R6: `in_data` is ignored when `in_valid` = 0. Results after the gap use only accepted samples.
- R7: The result is the zero-extended unsigned total and never wraps. An all-15 input gives 105.
- R8: A reset in the middle of a stream clears every stage flag. Three new samples must be accepted again before `out_valid` returns.
- R9: Reset is asynchronous and active low. `out_valid` drops as soon as `rst_n` falls, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 4 | Unsigned input sample |
| in_valid | input | 1 | Sample strobe, high when `in_data` is to be accepted |
| out_data | output | 10 | Filtered result, 0 when not valid |
| out_valid | output | 1 | High for one cycle per valid filtered result |

## Verification
A rising ramp gives every tap a distinct value, so a swapped weight or a misordered delay stage changes the result. Single-impulse streams place one nonzero sample in each tap position in turn, so the output shows each weight on its own. Streams with idle cycles carry junk on `in_data`. They expose a delay line that shifts without the strobe, or an output flag that survives a gap. All-maximum samples probe the top of the sum range. Resets in the middle of a stream, both at a clock edge and between edges, tell a correct flag clear apart from a delay line that is cleared but keeps its fill state.

// File: rtl/fir4_pkg.sv
package fir4_pkg;

  localparam int NUM_TAPS = 4;

  // fixed weight for a tap position, position 0 being the newest sample
  function automatic int unsigned tap_weight(input int unsigned pos);
    case (pos)
      0:       return 1;
      1:       return 3;
      2:       return 2;
      3:       return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned weight_total();
    int unsigned acc;
    acc = 0;
    for (int unsigned i = 0; i < NUM_TAPS; i++) acc += tap_weight(i);
    return acc;
  endfunction

  // weighted product of one tap, computed in a width that cannot wrap
  function automatic logic [15:0] weigh(input logic [7:0] sample, input int unsigned pos);
    logic [15:0] w;
    w = 16'(tap_weight(pos));
    return 16'(sample) * w;
  endfunction

endpackage

// File: rtl/fir4_delay_line.sv
module fir4_delay_line
  import fir4_pkg::*;
#(
  parameter int DATA_W = 4,
  localparam int STAGES = NUM_TAPS - 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [DATA_W-1:0]                  in_data,
  input  logic                               in_valid,
  output logic [NUM_TAPS-1:0][DATA_W-1:0]    taps,
  output logic                               taps_full
);

  logic [STAGES-1:0][DATA_W-1:0] stage_q;
  logic [STAGES-1:0]             stage_vld_q;
  logic                          shift_en;

  assign shift_en = in_valid;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [DATA_W-1:0] src_data;
      logic              src_vld;
      if (g == 0) begin : g_head
        assign src_data = in_data;
        assign src_vld  = 1'b1;
      end else begin : g_body
        assign src_data = stage_q[g-1];
        assign src_vld  = stage_vld_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[g]     <= '0;
          stage_vld_q[g] <= 1'b0;
        end else if (shift_en) begin
          stage_q[g]     <= src_data;
          stage_vld_q[g] <= src_vld;
        end
      end
      assign taps[g+1] = stage_q[g];
    end
  endgenerate

  assign taps[0]   = in_data;
  assign taps_full = &stage_vld_q;

  // R4
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(stage_q) && $stable(stage_vld_q)));

  // R3
  fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_vld_q[STAGES-1] |-> (&stage_vld_q));

  // R8
  flags_follow_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stage_vld_q[0]) |-> $past(in_valid));

endmodule

// File: rtl/fir4_tap_sum.sv
module fir4_tap_sum
  import fir4_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int SUM_W  = 10,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic [NUM_TAPS-1:0][DATA_W-1:0] taps,
  output logic [SUM_W-1:0]                total
);

  logic [NUM_TAPS-1:0][PROD_W-1:0] prod;

  genvar g;
  generate
    for (g = 0; g < NUM_TAPS; g++) begin : g_mul
      logic [15:0] wide;
      assign wide    = weigh(8'(taps[g]), g);
      assign prod[g] = wide[PROD_W-1:0];
    end
  endgenerate

  always_comb begin
    total = '0;
    for (int i = 0; i < NUM_TAPS; i++) total = total + SUM_W'(prod[i]);
  end

endmodule

// File: rtl/fir4_out_stage.sv
module fir4_out_stage #(
  parameter int SUM_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUM_W-1:0] total,
  input  logic             take,
  output logic [SUM_W-1:0] out_data,
  output logic             out_valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= take;
      out_data  <= take ? total : '0;
    end
  end

endmodule

// File: rtl/fir4_stream.sv
module fir4_stream
  import fir4_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int OUT_W  = 10,
  localparam int SAMPLE_MAX = (1 << DATA_W) - 1,
  localparam int RESULT_MAX = SAMPLE_MAX * 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic [OUT_W-1:0]  out_data,
  output logic              out_valid
);

  logic [NUM_TAPS-1:0][DATA_W-1:0] taps;
  logic                            taps_full;
  logic [OUT_W-1:0]                tap_total;
  logic                            result_take;

  fir4_delay_line #(.DATA_W(DATA_W)) u_delay (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .taps      (taps),
    .taps_full (taps_full)
  );

  fir4_tap_sum #(.DATA_W(DATA_W), .SUM_W(OUT_W)) u_sum (
    .taps  (taps),
    .total (tap_total)
  );

  assign result_take = in_valid && taps_full;

  fir4_out_stage #(.SUM_W(OUT_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .total     (tap_total),
    .take      (result_take),
    .out_data  (out_data),
    .out_valid (out_valid)
  );

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(tap_total) <= RESULT_MAX);

  // R5
  quiet_when_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0));

  // R4
  valid_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid));

  // R2
  result_captured_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_take |=> (out_valid && out_data == $past(tap_total)));

  initial begin
    // R7
    weights_fit_chk: assert (weight_total() == 7);
  end

endmodule

// File: tb/fir4_stream_bench.sv
module fir4_stream_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic [9:0] out_data;
  logic       out_valid;

  int checks = 0;
  int fails = 0;
  int hist [3];
  int accepted = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fir4_stream u_fir4_stream (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .out_data  (out_data),
    .out_valid (out_valid)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bench_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check("R1 valid in reset", int'(out_valid), 0);
    check("R1 data in reset", int'(out_data), 0);
    rst_n = 1'b1;
    accepted = 0;
    for (int i = 0; i < 3; i++) hist[i] = 0;
    @(posedge clk); #1;
    check("R1 valid after release", int'(out_valid), 0);
    check("R1 data after release", int'(out_data), 0);
  endtask

  // offer one cycle and check the result one edge later
  task automatic step(input int d, input bit v, input string req);
    int exp;
    bit full;
    @(negedge clk);
    in_data = 4'(d);
    in_valid = v;
    @(posedge clk); #1;
    if (v) begin
      full = (accepted >= 3);
      exp = d + 3 * hist[0] + 2 * hist[1] + hist[2];
      check({req, " valid"}, int'(out_valid), int'(full));
      check({req, " data"}, int'(out_data), full ? exp : 0);
      hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = d;
      accepted++;
    end else begin
      check({req, " R4 idle valid"}, int'(out_valid), 0);
      check({req, " R5 idle data"}, int'(out_data), 0);
    end
  endtask

  task automatic t_fill_ramp();
    bench_reset();
    for (int i = 1; i <= 3; i++) step(i, 1'b1, "R3 fill");
    for (int i = 4; i <= 10; i++) step(i, 1'b1, "R2 ramp");
  endtask

  task automatic t_impulse();
    bench_reset();
    for (int i = 0; i < 3; i++) step(0, 1'b1, "R3 prime");
    step(9, 1'b1, "R2 impulse w0");
    step(0, 1'b1, "R2 impulse w1");
    step(0, 1'b1, "R2 impulse w2");
    step(0, 1'b1, "R2 impulse w3");
    step(0, 1'b1, "R2 impulse gone");
  endtask

  task automatic t_gaps();
    bench_reset();
    step(2, 1'b1, "R3 gap fill");
    step(15, 1'b0, "R6 junk");
    step(5, 1'b1, "R3 gap fill");
    step(12, 1'b0, "R6 junk");
    step(7, 1'b0, "R6 junk");
    step(1, 1'b1, "R3 gap fill");
    step(6, 1'b1, "R6 after gap");
    step(9, 1'b0, "R4 hold");
    step(3, 1'b1, "R6 after gap");
  endtask

  task automatic t_max();
    bench_reset();
    for (int i = 0; i < 6; i++) step(15, 1'b1, "R7 max");
    check("R7 peak value", int'(out_data), 105);
    step(15, 1'b1, "R7 alt"); step(0, 1'b1, "R7 alt"); step(15, 1'b1, "R7 alt");
  endtask

  task automatic t_mid_reset();
    bench_reset();
    for (int i = 0; i < 5; i++) step(i + 3, 1'b1, "R2 pre reset");
    bench_reset();
    for (int i = 0; i < 3; i++) step(8, 1'b1, "R8 refill");
    step(4, 1'b1, "R8 first after refill");
  endtask

  task automatic t_async_reset();
    bench_reset();
    for (int i = 0; i < 5; i++) step(6, 1'b1, "R2 steady");
    check("R9 valid before drop", int'(out_valid), 1);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    check("R9 valid drops at once", int'(out_valid), 0);
    check("R9 data drops at once", int'(out_data), 0);
  endtask

  initial begin
    t_fill_ramp();
    t_impulse();
    t_gaps();
    t_max();
    t_mid_reset();
    t_async_reset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule